// File: doc/BRIEF.md
# Lane Word Staging Unit

This block is a staging buffer that sits between a single 32-bit memory port and four lockstep processing lanes. It holds one 32-bit word per lane. A control unit issues one transfer command at a time and stalls until the block pulses its completion strobe. The lanes' register files and the memory array are outside the block. The block reaches them through a combinational lane read port, a lane write port and a request-style memory port.

Memory-side transfers move single words between memory and one chosen slot, or fill all four slots from four consecutive addresses. Indexed transfers form a memory address from two registers of one chosen lane. Because only one slot is touched per indexed command, the lanes take turns on the one memory port. Lane-side transfers move all four slots to or from one register index in every lane in a single cycle. A broadcast copies one slot into the same register of all four lanes.

Top module: `lane_stage_unit`

## Requirements
- R1: After synchronous reset, all slots read zero, `cmd_done` is low, and neither `mem_req` nor `rf_we` is asserted.
- R2: A command is taken only when `cmd_valid` is high while the unit is idle. The opcode encoding is 0 load, 1 store, 2 wide load, 3 slots-to-registers, 4 registers-to-slots, 5 broadcast, 6 indexed load, 7 indexed store. A command presented while a transfer is in progress is ignored and has no effect on slots or registers.
- R3: Load (0) places M[`cmd_addr`] into slot `cmd_slot`. It issues one read, captures the data in the following cycle, and raises `cmd_done` in the third cycle after acceptance.
- R4: Store (1) writes slot `cmd_slot` to M[`cmd_addr`] with a single write request and raises `cmd_done` in the second cycle after acceptance.
- R5: Wide load (2) fills slot k from M[`cmd_addr`+k] for k = 0..3. It uses four read/capture pairs and raises `cmd_done` in the ninth cycle after acceptance.
- R6: Slots-to-registers (3) writes slot k into register `cmd_rsel` of lane k for every lane at once. Lane k occupies bits [32k+31:32k] of every lane-wide bus. `cmd_done` follows in the second cycle.
- R7: Registers-to-slots (4) loads slot k from register `cmd_rsel` of lane k for every lane at once. `cmd_done` follows in the second cycle.
- R8: Broadcast (5) writes slot `cmd_slot` into register `cmd_rsel` of all four lanes, with identical data on every lane. `cmd_done` follows in the second cycle.
- R9: Indexed load (6) and indexed store (7) use the address R[`cmd_ra`]+R[`cmd_rb`] taken from lane `cmd_slot`. They move data between that address and slot `cmd_slot`, with the same timing as load and store.
- R10: Every computed address (indexed sum, wide-load offset) keeps only its low 14 bits, so it wraps modulo 16384.
- R11: `cmd_done` is a one-cycle pulse. In the cycle after it there is no memory request and no lane register write.
- R12: The memory port and the lane register write port are never active in the same cycle. A read request is always followed by a cycle with no request, in which the data is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command opcode |
| cmd_slot | input | 2 | Slot / lane selector |
| cmd_addr | input | 14 | Direct memory address |
| cmd_rsel | input | 5 | Lane register index for lane-side transfers |
| cmd_ra | input | 5 | First index register for indexed access |
| cmd_rb | input | 5 | Second index register for indexed access |
| cmd_done | output | 1 | Transfer complete pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 14 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after a read request |
| rf_raddr_a | output | 5 | Lane register read index A (all lanes) |
| rf_raddr_b | output | 5 | Lane register read index B (all lanes) |
| rf_rdata_a | input | 128 | Read data A from all lanes |
| rf_rdata_b | input | 128 | Read data B from all lanes |
| rf_we | output | 1 | Lane register write enable |
| rf_waddr | output | 5 | Lane register write index |
| rf_wdata | output | 128 | Write data to all lanes |
| slot_q | output | 128 | Current slot contents, lane-packed |

## Verification
The properties assume that memory returns read data exactly one cycle after a read request, and that the lane read ports answer combinationally in the same cycle the index is driven. The stimulus keeps to this with a registered memory model and a combinational register-file model. Commands are driven only in the idle cycle that follows a completion pulse, except in the one case that deliberately offers a command mid-transfer. Indexed and wide addresses are chosen both below and across the 14-bit boundary.

// File: rtl/stg_pkg.sv
`timescale 1ns/1ps
package stg_pkg;
    localparam int LANES  = 4;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 14;
    localparam int RIDX_W = 5;
    localparam int SLOT_W = $clog2(LANES);
    localparam int BUS_W  = LANES * WORD_W;

    typedef enum logic [2:0] {
        OP_LD  = 3'd0,
        OP_ST  = 3'd1,
        OP_LDW = 3'd2,
        OP_LDR = 3'd3,
        OP_STR = 3'd4,
        OP_BC  = 3'd5,
        OP_LDX = 3'd6,
        OP_STX = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_XFER,
        ST_DONE
    } fsm_e;

    typedef struct packed {
        op_e               op;
        logic [SLOT_W-1:0] slot;
        logic [ADDR_W-1:0] addr;
        logic [RIDX_W-1:0] rsel;
        logic [RIDX_W-1:0] ra;
        logic [RIDX_W-1:0] rb;
    } cmd_t;

    // lane-side transfer: no memory traffic
    function automatic logic is_reg_side(input op_e op);
        return (op == OP_LDR) || (op == OP_STR) || (op == OP_BC);
    endfunction

    function automatic logic is_store(input op_e op);
        return (op == OP_ST) || (op == OP_STX);
    endfunction

    // sum of two lane words, wrapped into the memory range
    function automatic logic [ADDR_W-1:0] wrap_add(input logic [WORD_W-1:0] a,
                                                   input logic [WORD_W-1:0] b);
        logic [WORD_W-1:0] s;
        s = a + b;
        return s[ADDR_W-1:0];
    endfunction
endpackage

// File: rtl/stg_ctrl.sv
`timescale 1ns/1ps
module stg_ctrl
    import stg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  op_e               new_op,
    input  op_e               cur_op,
    output logic              accept,
    output logic [SLOT_W-1:0] beat,
    output logic              mem_issue,
    output logic              mem_write,
    output logic              capture,
    output logic              xfer,
    output logic              done
);
    localparam logic [SLOT_W-1:0] LAST_BEAT = SLOT_W'(LANES - 1);

    fsm_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            beat  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        beat  <= '0;
                        state <= is_reg_side(new_op) ? ST_XFER : ST_ISSUE;
                    end
                end
                ST_ISSUE: state <= is_store(cur_op) ? ST_DONE : ST_WAIT;
                ST_WAIT: begin
                    if (cur_op == OP_LDW && beat != LAST_BEAT) begin
                        beat  <= beat + 1'b1;
                        state <= ST_ISSUE;
                    end else begin
                        state <= ST_DONE;
                    end
                end
                ST_XFER: state <= ST_DONE;
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        accept    = (state == ST_IDLE) && cmd_valid;
        mem_issue = (state == ST_ISSUE);
        mem_write = mem_issue && is_store(cur_op);
        capture   = (state == ST_WAIT);
        xfer      = (state == ST_XFER);
        done      = (state == ST_DONE);
    end
endmodule

// File: rtl/stg_addr.sv
`timescale 1ns/1ps
module stg_addr
    import stg_pkg::*;
(
    input  cmd_t              cmd,
    input  logic [SLOT_W-1:0] beat,
    input  logic [BUS_W-1:0]  rd_a,
    input  logic [BUS_W-1:0]  rd_b,
    output logic [RIDX_W-1:0] raddr_a,
    output logic [RIDX_W-1:0] raddr_b,
    output logic [ADDR_W-1:0] addr
);
    logic [WORD_W-1:0] lane_a;
    logic [WORD_W-1:0] lane_b;

    // only the lane named by the slot field forms the indexed address
    assign lane_a = rd_a[cmd.slot*WORD_W +: WORD_W];
    assign lane_b = rd_b[cmd.slot*WORD_W +: WORD_W];

    assign raddr_a = (cmd.op == OP_STR) ? cmd.rsel : cmd.ra;
    assign raddr_b = cmd.rb;

    always_comb begin
        unique case (cmd.op)
            OP_LDX, OP_STX: addr = wrap_add(lane_a, lane_b);
            OP_LDW:         addr = cmd.addr + ADDR_W'(beat);
            default:        addr = cmd.addr;
        endcase
    end
endmodule

// File: rtl/stg_slots.sv
`timescale 1ns/1ps
module stg_slots
    import stg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [SLOT_W-1:0] cap_idx,
    input  logic [WORD_W-1:0] cap_data,
    input  logic              bulk_en,
    input  logic [BUS_W-1:0]  bulk_data,
    output logic [BUS_W-1:0]  slot_q
);
    for (genvar g = 0; g < LANES; g++) begin : g_slot
        logic [WORD_W-1:0] word_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (bulk_en) begin
                word_q <= bulk_data[g*WORD_W +: WORD_W];
            end else if (cap_en && cap_idx == SLOT_W'(g)) begin
                word_q <= cap_data;
            end
        end

        assign slot_q[g*WORD_W +: WORD_W] = word_q;
    end
endmodule

// File: rtl/lane_stage_unit.sv
`timescale 1ns/1ps
module lane_stage_unit
    import stg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [SLOT_W-1:0] cmd_slot,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [RIDX_W-1:0] cmd_rsel,
    input  logic [RIDX_W-1:0] cmd_ra,
    input  logic [RIDX_W-1:0] cmd_rb,
    output logic              cmd_done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [RIDX_W-1:0] rf_raddr_a,
    output logic [RIDX_W-1:0] rf_raddr_b,
    input  logic [BUS_W-1:0]  rf_rdata_a,
    input  logic [BUS_W-1:0]  rf_rdata_b,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_waddr,
    output logic [BUS_W-1:0]  rf_wdata,
    output logic [BUS_W-1:0]  slot_q
);
    cmd_t              cmd_q;
    op_e               cur_op;
    logic              accept;
    logic [SLOT_W-1:0] beat;
    logic              mem_issue;
    logic              mem_write;
    logic              capture;
    logic              xfer;
    logic [WORD_W-1:0] sel_word;
    logic [SLOT_W-1:0] cap_idx;

    assign cur_op = cmd_q.op;

    // command latch: held for the whole transfer
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (accept) begin
            cmd_q <= '{op:   op_e'(cmd_op),
                       slot: cmd_slot,
                       addr: cmd_addr,
                       rsel: cmd_rsel,
                       ra:   cmd_ra,
                       rb:   cmd_rb};
        end
    end

    stg_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .new_op    (op_e'(cmd_op)),
        .cur_op    (cur_op),
        .accept    (accept),
        .beat      (beat),
        .mem_issue (mem_issue),
        .mem_write (mem_write),
        .capture   (capture),
        .xfer      (xfer),
        .done      (cmd_done)
    );

    stg_addr u_addr (
        .cmd     (cmd_q),
        .beat    (beat),
        .rd_a    (rf_rdata_a),
        .rd_b    (rf_rdata_b),
        .raddr_a (rf_raddr_a),
        .raddr_b (rf_raddr_b),
        .addr    (mem_addr)
    );

    assign cap_idx = (cur_op == OP_LDW) ? beat : cmd_q.slot;

    stg_slots u_slots (
        .clk       (clk),
        .rst       (rst),
        .cap_en    (capture),
        .cap_idx   (cap_idx),
        .cap_data  (mem_rdata),
        .bulk_en   (xfer && cur_op == OP_STR),
        .bulk_data (rf_rdata_a),
        .slot_q    (slot_q)
    );

    assign sel_word  = slot_q[cmd_q.slot*WORD_W +: WORD_W];

    assign mem_req   = mem_issue;
    assign mem_we    = mem_write;
    assign mem_wdata = sel_word;

    assign rf_we     = xfer && (cur_op == OP_LDR || cur_op == OP_BC);
    assign rf_waddr  = cmd_q.rsel;
    assign rf_wdata  = (cur_op == OP_BC) ? {LANES{sel_word}} : slot_q;
endmodule

// File: rtl/stg_checker.sv
`timescale 1ns/1ps
module stg_checker
    import stg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             done,
    input logic             mem_req,
    input logic             mem_we,
    input logic             rf_we,
    input logic [BUS_W-1:0] rf_wdata,
    input op_e              cur_op
);
    function automatic logic lanes_equal(input logic [BUS_W-1:0] bus);
        logic eq;
        eq = 1'b1;
        for (int k = 1; k < LANES; k++) begin
            if (bus[k*WORD_W +: WORD_W] != bus[WORD_W-1:0]) eq = 1'b0;
        end
        return eq;
    endfunction

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11
    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!mem_req && !rf_we)); // R11
    AST_BUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && rf_we)); // R12
    AST_READ_GAP: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> !mem_req); // R12
    AST_STORE_FINISH: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |=> done); // R4
    AST_BC_UNIFORM: assert property (@(posedge clk) disable iff (rst)
        (rf_we && cur_op == OP_BC) |-> lanes_equal(rf_wdata)); // R8
endmodule

bind lane_stage_unit stg_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .done     (cmd_done),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .rf_we    (rf_we),
    .rf_wdata (rf_wdata),
    .cur_op   (cur_op)
);

// File: tb/lane_stage_unit_test.sv
`timescale 1ns/1ps
module lane_stage_unit_test;
    import stg_pkg::*;

    localparam int MEM_WORDS = 1 << ADDR_W;
    localparam int NREGS     = 1 << RIDX_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_op    = '0;
    logic [SLOT_W-1:0] cmd_slot  = '0;
    logic [ADDR_W-1:0] cmd_addr  = '0;
    logic [RIDX_W-1:0] cmd_rsel  = '0;
    logic [RIDX_W-1:0] cmd_ra    = '0;
    logic [RIDX_W-1:0] cmd_rb    = '0;
    logic              cmd_done;
    logic              mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [WORD_W-1:0] mem_wdata;
    logic [WORD_W-1:0] mem_rdata;
    logic [RIDX_W-1:0] rf_raddr_a, rf_raddr_b, rf_waddr;
    logic [BUS_W-1:0]  rf_rdata_a, rf_rdata_b, rf_wdata, slot_q;
    logic              rf_we;

    lane_stage_unit uut (.*);

    // ---------------- environment: memory and lane register files ----------
    logic [WORD_W-1:0] env_mem [MEM_WORDS];
    logic [WORD_W-1:0] env_rf  [LANES][NREGS];

    function automatic logic [WORD_W-1:0] mem_init(input int i);
        return (WORD_W'(i) * 32'd13 + 32'd7) ^ 32'hA500_0000;
    endfunction

    function automatic logic [WORD_W-1:0] rf_init(input int l, input int r);
        if (l == 2 && r == 20) return 32'd16380;
        if (l == 2 && r == 21) return 32'd10;
        return WORD_W'((l + 1) * 1000 + r);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_WORDS; i++) env_mem[i] <= mem_init(i);
            mem_rdata <= '0;
        end else if (mem_req) begin
            if (mem_we) env_mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= env_mem[mem_addr];
        end
    end

    always @(posedge clk) begin
        if (rst) begin
            for (int l = 0; l < LANES; l++)
                for (int r = 0; r < NREGS; r++) env_rf[l][r] <= rf_init(l, r);
        end else if (rf_we) begin
            for (int l = 0; l < LANES; l++)
                env_rf[l][rf_waddr] <= rf_wdata[l*WORD_W +: WORD_W];
        end
    end

    always @* begin
        for (int l = 0; l < LANES; l++) begin
            rf_rdata_a[l*WORD_W +: WORD_W] = env_rf[l][rf_raddr_a];
            rf_rdata_b[l*WORD_W +: WORD_W] = env_rf[l][rf_raddr_b];
        end
    end

    // ---------------- reference model ---------------------------------------
    logic [WORD_W-1:0] ref_mem  [MEM_WORDS];
    logic [WORD_W-1:0] ref_rf   [LANES][NREGS];
    logic [WORD_W-1:0] ref_slot [LANES];

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string tag,
                         input logic [BUS_W-1:0] act, input logic [BUS_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [BUS_W-1:0] ref_slots_bus();
        logic [BUS_W-1:0] v;
        for (int k = 0; k < LANES; k++) v[k*WORD_W +: WORD_W] = ref_slot[k];
        return v;
    endfunction

    task automatic run_op(input op_e op, input int slot, input int addr,
                          input int rsel, input int ra, input int rb,
                          input bit inject, input string tag);
        int lat;
        int a;
        logic [BUS_W-1:0] act_rf, exp_rf;
        lat = (op == OP_LDW) ? 9 : ((op == OP_LD || op == OP_LDX) ? 3 : 2);
        @(negedge clk);
        // R11: idle cycle after the previous completion is quiet
        check(!cmd_done && !mem_req && !rf_we, "R11 quiet after done",
              BUS_W'({cmd_done, mem_req, rf_we}), '0);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_slot  = slot[SLOT_W-1:0];
        cmd_addr  = addr[ADDR_W-1:0];
        cmd_rsel  = rsel[RIDX_W-1:0];
        cmd_ra    = ra[RIDX_W-1:0];
        cmd_rb    = rb[RIDX_W-1:0];
        for (int n = 1; n <= lat; n++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            if (inject && n == 2) begin
                cmd_valid = 1'b1;      // R2: offered while busy
                cmd_op    = OP_STR;
                cmd_rsel  = 5'd1;
            end
            check(cmd_done == (n == lat), {tag, " done timing"},
                  BUS_W'(cmd_done), BUS_W'(n == lat));
        end
        cmd_valid = 1'b0;
        // update the reference for this command
        a = 0;
        if (op == OP_LDX || op == OP_STX)
            a = int'((ref_rf[slot][ra] + ref_rf[slot][rb]) % MEM_WORDS);
        case (op)
            OP_LD:  ref_slot[slot] = ref_mem[addr];
            OP_ST:  ref_mem[addr] = ref_slot[slot];
            OP_LDW: for (int k = 0; k < LANES; k++)
                        ref_slot[k] = ref_mem[(addr + k) % MEM_WORDS];
            OP_LDR: for (int k = 0; k < LANES; k++) ref_rf[k][rsel] = ref_slot[k];
            OP_STR: for (int k = 0; k < LANES; k++) ref_slot[k] = ref_rf[k][rsel];
            OP_BC:  for (int k = 0; k < LANES; k++) ref_rf[k][rsel] = ref_slot[slot];
            OP_LDX: ref_slot[slot] = ref_mem[a];
            OP_STX: ref_mem[a] = ref_slot[slot];
            default: ;
        endcase
        check(slot_q == ref_slots_bus(), {tag, " slots"}, slot_q, ref_slots_bus());
        if (op == OP_ST)
            check(env_mem[addr] == ref_mem[addr], {tag, " memory word"},
                  BUS_W'(env_mem[addr]), BUS_W'(ref_mem[addr]));
        if (op == OP_STX)
            check(env_mem[a] == ref_mem[a], {tag, " memory word"},
                  BUS_W'(env_mem[a]), BUS_W'(ref_mem[a]));
        if (op == OP_LDR || op == OP_BC) begin
            for (int k = 0; k < LANES; k++) begin
                act_rf[k*WORD_W +: WORD_W] = env_rf[k][rsel];
                exp_rf[k*WORD_W +: WORD_W] = ref_rf[k][rsel];
            end
            check(act_rf == exp_rf, {tag, " lane registers"}, act_rf, exp_rf);
        end
    endtask

    // ---------------- watchdog ---------------------------------------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !finished) begin
            finished = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    // ---------------- stimulus ---------------------------------------------
    initial begin
        for (int i = 0; i < MEM_WORDS; i++) ref_mem[i] = mem_init(i);
        for (int l = 0; l < LANES; l++) begin
            ref_slot[l] = '0;
            for (int r = 0; r < NREGS; r++) ref_rf[l][r] = rf_init(l, r);
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(slot_q == '0, "R1 slots after reset", slot_q, '0);
        check(!cmd_done && !mem_req && !rf_we, "R1 strobes after reset",
              BUS_W'({cmd_done, mem_req, rf_we}), '0);

        // R3 single loads into each slot; R12 read then capture
        run_op(OP_LD, 0, 104, 0, 0, 0, 1'b0, "R3 ld slot0");
        run_op(OP_LD, 1, 105, 0, 0, 0, 1'b0, "R3 ld slot1");
        run_op(OP_LD, 2, 106, 0, 0, 0, 1'b0, "R3 ld slot2");
        run_op(OP_LD, 3, 107, 0, 0, 0, 1'b0, "R3 ld slot3");
        // R6 slots to registers
        run_op(OP_LDR, 0, 0, 0, 0, 0, 1'b0, "R6 ldr r0");
        // R5 wide load
        run_op(OP_LDW, 0, 200, 0, 0, 0, 1'b0, "R5 ldw 200");
        // R7 registers to slots
        run_op(OP_STR, 0, 0, 7, 0, 0, 1'b0, "R7 str r7");
        // R4 store
        run_op(OP_ST, 2, 300, 0, 0, 0, 1'b0, "R4 st slot2");
        // R8 broadcast
        run_op(OP_BC, 1, 0, 9, 0, 0, 1'b0, "R8 bc slot1 r9");
        // R9 indexed load from lane 3 and indexed store from lane 0
        run_op(OP_LDX, 3, 0, 0, 1, 2, 1'b0, "R9 ldx lane3");
        run_op(OP_STX, 0, 0, 0, 3, 4, 1'b0, "R9 stx lane0");
        // R10 wrap of indexed sum (16390 -> 6) and of wide-load offsets
        run_op(OP_LDX, 2, 0, 0, 20, 21, 1'b0, "R10 ldx wrap");
        run_op(OP_LDW, 0, 16382, 0, 0, 0, 1'b0, "R10 ldw wrap");
        // R2 command offered while busy is ignored
        run_op(OP_LDW, 0, 400, 0, 0, 0, 1'b1, "R2 busy ignore");
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            check(!cmd_done && slot_q == ref_slots_bus(), "R2 no extra transfer",
                  slot_q, ref_slots_bus());
        end
        run_op(OP_STR, 0, 0, 1, 0, 0, 1'b0, "R7 str r1");

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule